// File: doc/BRIEF.md
# ECC Uncorrectable-Error Capture and Fault Injection

This block sits beside an ECC-protected memory controller and gives software a view of memory faults. It watches every read returning from memory, together with the uncorrectable flag raised by an external ECC decoder. On the first read flagged as uncorrectable, it records the raw data and check bits, which have not been corrected. It then freezes that record and raises a status bit. The record holds until software writes 1 to the status bit. That write re-arms the capture so that the next uncorrectable read is recorded. Capture is armed as soon as reset ends.

On the write side, the block passes write data and check bits through to memory. Software can load a one-shot injection mask. Each set bit of the mask inverts the matching bit of the low 32-bit data word on the next write. The check bits of that write are passed through unchanged, so the stored word is deliberately inconsistent with its ECC. The mask clears itself after that single write.

The parameter `DQ_WIDTH` selects the memory data path. A value of 72 gives 64 data bits and 8 check bits. A value of 144 gives 128 data bits and 16 check bits. Software reaches all state through a simple word-addressed register port with combinational read data. The register map is: 0x0 status (bit 0), 0x4 to 0x7 captured data words 0 to 3, 0x8 captured check bits, 0xC injection mask. Any other address reads as zero.

Top module: `ecc_err_monitor`

## Requirements
- R1: After reset, the status bit, every captured data word, the captured check register and the injection mask all read as zero, and capture is armed.
- R2: While the status bit is 0, a read with `rd_valid`=1 and `rd_ue`=1 stores `rd_data` and `rd_ecc` and sets the status bit. All three values are visible on `reg_rdata` from the next cycle.
- R3: While the status bit is 1, further uncorrectable reads leave the captured data and check bits unchanged.
- R4: A register write to address 0x0 with `reg_wdata[0]`=1 clears the status bit on the next cycle and re-arms capture. A write with `reg_wdata[0]`=0 changes nothing.
- R5: If a clear write and an uncorrectable read occur in the same cycle, the new read is captured and the status bit stays 1.
- R6: Reads with `rd_ue`=0, or with `rd_valid`=0, never change the captured values or the status bit.
- R7: Address 0x8 returns the captured check bits in bits [ECC_W-1:0], with ECC_W = 16 for `DQ_WIDTH`=144 and 8 for `DQ_WIDTH`=72. The upper bits read as zero.
- R8: Address 0x4+k returns captured data bits [32k+31:32k]. Words 2 and 3 exist only when `DQ_WIDTH`=144 and otherwise read as zero. Status reads at 0x0 as bit 0 with all other bits zero. Unmapped addresses read as zero.
- R9: `wr_data_out` equals `wr_data_in` with bits [31:0] XORed by the current injection mask and bits above 31 untouched. `wr_ecc_out` always equals `wr_ecc_in`.
- R10: A register write to address 0xC loads the injection mask, which reads back at 0xC. The mask holds through cycles with `wr_valid`=0 and reads zero after exactly one cycle with `wr_valid`=1.
- R11: When a mask write and `wr_valid`=1 occur in the same cycle, that write uses the old mask and the new mask value is retained.
- R12: Register writes to addresses 0x4 through 0x8 have no effect on any readable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| rd_valid | input | 1 | A memory read returns this cycle |
| rd_data | input | DATA_W (128) | Raw read data, uncorrected |
| rd_ecc | input | ECC_W (16) | Raw read check bits |
| rd_ue | input | 1 | Decoder flags this read uncorrectable |
| wr_valid | input | 1 | A memory write is issued this cycle |
| wr_data_in | input | DATA_W (128) | Write data from the controller |
| wr_ecc_in | input | ECC_W (16) | Check bits from the encoder |
| wr_data_out | output | DATA_W (128) | Write data to memory, possibly corrupted |
| wr_ecc_out | output | ECC_W (16) | Check bits to memory |

## Verification
A wrong freeze or arm state shows up one cycle after the first uncorrectable read that should, or should not, be stored: the captured words at 0x4 to 0x8 and the status bit at 0x0 differ from the value expected after that read. A mask that lingers or clears early is visible at once on `wr_data_out` during the next write, and in the readback at 0xC in the following cycle. The bench therefore compares every readable register and both write outputs in every cycle against a reference model. The random reads and writes are interleaved with same-cycle clear/capture and mask-load/write collisions.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADR_STATUS = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_WORD0  = 4'h4;
    localparam logic [ADDR_W-1:0] ADR_WORD1  = 4'h5;
    localparam logic [ADDR_W-1:0] ADR_WORD2  = 4'h6;
    localparam logic [ADDR_W-1:0] ADR_WORD3  = 4'h7;
    localparam logic [ADDR_W-1:0] ADR_CHECK  = 4'h8;
    localparam logic [ADDR_W-1:0] ADR_INJECT = 4'hC;

    localparam int MAX_WORDS = 4;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  wdata;
    } reg_req_t;

    function automatic int data_width(input int dq);
        return (dq == 144) ? 128 : 64;
    endfunction

    function automatic int check_width(input int dq);
        return (dq == 144) ? 16 : 8;
    endfunction

endpackage

// File: rtl/ecc_capture_unit.sv
module ecc_capture_unit #(
    parameter int DATA_W = 128,
    parameter int ECC_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [ECC_W-1:0]  rd_ecc,
    input  logic              rd_ue,
    input  logic              clear_req,
    output logic              status,
    output logic [DATA_W-1:0] cap_data,
    output logic [ECC_W-1:0]  cap_ecc
);

    logic armed;
    logic fire;

    // a pending clear re-opens the window in the same cycle
    assign armed = !status || clear_req;
    assign fire  = rd_valid && rd_ue && armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            status   <= 1'b0;
            cap_data <= '0;
            cap_ecc  <= '0;
        end else if (fire) begin
            status   <= 1'b1;
            cap_data <= rd_data;
            cap_ecc  <= rd_ecc;
        end else if (clear_req) begin
            status   <= 1'b0;
        end
    end

    AST_CAPTURE_DATA: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ue && !status) |=> (cap_data == $past(rd_data) && cap_ecc == $past(rd_ecc) && status)); // R2

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (status && !clear_req) |=> ($stable(cap_data) && $stable(cap_ecc) && status)); // R3

    AST_CLEAR_REARM: assert property (@(posedge clk) disable iff (rst)
        (clear_req && !(rd_valid && rd_ue)) |=> !status); // R4

    AST_CLEAR_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        (clear_req && rd_valid && rd_ue) |=> (status && cap_data == $past(rd_data))); // R5

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && rd_ue) |=> ($stable(cap_data) && $stable(cap_ecc))); // R6

endmodule

// File: rtl/ecc_inject_unit.sv
module ecc_inject_unit #(
    parameter int DATA_W = 128,
    parameter int ECC_W  = 16,
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic [MASK_W-1:0] mask_wdata,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data_in,
    input  logic [ECC_W-1:0]  wr_ecc_in,
    output logic [MASK_W-1:0] mask,
    output logic [DATA_W-1:0] wr_data_out,
    output logic [ECC_W-1:0]  wr_ecc_out
);

    localparam int PAD_W = DATA_W - MASK_W;

    logic [DATA_W-1:0] flip;

    assign flip        = {{PAD_W{1'b0}}, mask};
    assign wr_data_out = wr_data_in ^ flip;
    assign wr_ecc_out  = wr_ecc_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (mask_we) begin
            mask <= mask_wdata;
        end else if (wr_valid) begin
            mask <= '0;
        end
    end

    AST_MASK_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !mask_we) |=> (mask == '0)); // R10

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_valid && !mask_we) |=> $stable(mask)); // R10

    AST_MASK_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (mask == $past(mask_wdata))); // R11

    always_comb begin
        if (!rst) begin
            AST_UPPER_UNTOUCHED: assert (wr_data_out[DATA_W-1:MASK_W] == wr_data_in[DATA_W-1:MASK_W]); // R9
        end
    end

endmodule

// File: rtl/ecc_reg_file.sv
module ecc_reg_file
    import ecc_cap_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int ECC_W  = 16
) (
    input  reg_req_t          req,
    input  logic              status,
    input  logic [DATA_W-1:0] cap_data,
    input  logic [ECC_W-1:0]  cap_ecc,
    input  logic [REG_W-1:0]  mask,
    output logic [REG_W-1:0]  rdata,
    output logic              clear_req,
    output logic              mask_we
);

    localparam int N_WORDS = DATA_W / REG_W;

    logic [REG_W-1:0] word [MAX_WORDS];

    for (genvar k = 0; k < MAX_WORDS; k++) begin : g_word
        if (k < N_WORDS) begin : g_live
            assign word[k] = cap_data[k*REG_W +: REG_W];
        end else begin : g_absent
            assign word[k] = '0;
        end
    end

    assign clear_req = req.we && (req.addr == ADR_STATUS) && req.wdata[0];
    assign mask_we   = req.we && (req.addr == ADR_INJECT);

    always_comb begin
        rdata = '0;
        case (req.addr)
            ADR_STATUS: rdata = {{(REG_W-1){1'b0}}, status};
            ADR_WORD0:  rdata = word[0];
            ADR_WORD1:  rdata = word[1];
            ADR_WORD2:  rdata = word[2];
            ADR_WORD3:  rdata = word[3];
            ADR_CHECK:  rdata = {{(REG_W-ECC_W){1'b0}}, cap_ecc};
            ADR_INJECT: rdata = mask;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecc_err_monitor.sv
module ecc_err_monitor
    import ecc_cap_pkg::*;
#(
    parameter int DQ_WIDTH = 144,
    localparam int DATA_W  = data_width(DQ_WIDTH),
    localparam int ECC_W   = check_width(DQ_WIDTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [ECC_W-1:0]  rd_ecc,
    input  logic              rd_ue,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data_in,
    input  logic [ECC_W-1:0]  wr_ecc_in,
    output logic [DATA_W-1:0] wr_data_out,
    output logic [ECC_W-1:0]  wr_ecc_out
);

    reg_req_t          req;
    logic              clear_req;
    logic              mask_we;
    logic              status;
    logic [DATA_W-1:0] cap_data;
    logic [ECC_W-1:0]  cap_ecc;
    logic [REG_W-1:0]  mask;

    assign req = '{we: reg_we, addr: reg_addr, wdata: reg_wdata};

    ecc_reg_file #(.DATA_W(DATA_W), .ECC_W(ECC_W)) u_regs (
        .req       (req),
        .status    (status),
        .cap_data  (cap_data),
        .cap_ecc   (cap_ecc),
        .mask      (mask),
        .rdata     (reg_rdata),
        .clear_req (clear_req),
        .mask_we   (mask_we)
    );

    ecc_capture_unit #(.DATA_W(DATA_W), .ECC_W(ECC_W)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_ecc    (rd_ecc),
        .rd_ue     (rd_ue),
        .clear_req (clear_req),
        .status    (status),
        .cap_data  (cap_data),
        .cap_ecc   (cap_ecc)
    );

    ecc_inject_unit #(.DATA_W(DATA_W), .ECC_W(ECC_W), .MASK_W(REG_W)) u_inject (
        .clk         (clk),
        .rst         (rst),
        .mask_we     (mask_we),
        .mask_wdata  (reg_wdata),
        .wr_valid    (wr_valid),
        .wr_data_in  (wr_data_in),
        .wr_ecc_in   (wr_ecc_in),
        .mask        (mask),
        .wr_data_out (wr_data_out),
        .wr_ecc_out  (wr_ecc_out)
    );

    AST_ECC_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        wr_ecc_out == wr_ecc_in); // R9

endmodule

// File: tb/test_ecc_err_monitor.sv
module test_ecc_err_monitor;

    localparam int DW = 128;
    localparam int EW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          rd_valid = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic [EW-1:0] rd_ecc = '0;
    logic          rd_ue = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data_in = '0;
    logic [EW-1:0] wr_ecc_in = '0;
    logic [DW-1:0] wr_data_out;
    logic [EW-1:0] wr_ecc_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic          m_st = 1'b0;
    logic [DW-1:0] m_data = '0;
    logic [EW-1:0] m_ecc = '0;
    logic [31:0]   m_mask = '0;

    always #10 clk = ~clk;

    ecc_err_monitor #(.DQ_WIDTH(144)) i_ecc_err_monitor (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_ecc(rd_ecc), .rd_ue(rd_ue),
        .wr_valid(wr_valid), .wr_data_in(wr_data_in), .wr_ecc_in(wr_ecc_in),
        .wr_data_out(wr_data_out), .wr_ecc_out(wr_ecc_out)
    );

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a)
            4'h0: return {31'b0, m_st};
            4'h4: return m_data[31:0];
            4'h5: return m_data[63:32];
            4'h6: return m_data[95:64];
            4'h7: return m_data[127:96];
            4'h8: return {16'b0, m_ecc};
            4'hC: return m_mask;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'h0: return "R4";
            4'h8: return "R7";
            4'hC: return "R10";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [3:0] a, input string req);
        reg_addr = a;
        #1;
        chk(req, {96'b0, reg_rdata}, {96'b0, exp_read(a)});
    endtask

    task automatic peek_all(input string req);
        peek(4'h0, req); peek(4'h4, req); peek(4'h5, req); peek(4'h6, req);
        peek(4'h7, req); peek(4'h8, req); peek(4'hC, req); peek(4'h3, req);
    endtask

    // inputs already driven; check comb outputs, clock once, update model
    task automatic step();
        logic clr;
        #1;
        chk(tag_of(reg_addr), {96'b0, reg_rdata}, {96'b0, exp_read(reg_addr)});
        chk("R9", wr_data_out, wr_data_in ^ {96'b0, m_mask});
        chk("R9", {112'b0, wr_ecc_out}, {112'b0, wr_ecc_in});
        @(posedge clk);
        clr = reg_we && reg_addr == 4'h0 && reg_wdata[0];
        if (rd_valid && rd_ue && (!m_st || clr)) begin
            m_st = 1'b1; m_data = rd_data; m_ecc = rd_ecc;
        end else if (clr) begin
            m_st = 1'b0;
        end
        if (reg_we && reg_addr == 4'hC) m_mask = reg_wdata;
        else if (wr_valid) m_mask = '0;
        @(negedge clk);
        reg_we = 1'b0; rd_valid = 1'b0; rd_ue = 1'b0; wr_valid = 1'b0;
    endtask

    function automatic logic [DW-1:0] rnd_wide();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic ue_read(input logic [DW-1:0] d, input logic [EW-1:0] e);
        rd_valid = 1'b1; rd_ue = 1'b1; rd_data = d; rd_ecc = e;
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d1;
        logic [DW-1:0] d2;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        peek_all("R1");

        d1 = rnd_wide();
        ue_read(d1, 16'hA5C3); step();
        peek_all("R2");
        ue_read(rnd_wide(), 16'h1111); step();
        peek_all("R3");
        rd_valid = 1'b1; rd_ue = 1'b0; rd_data = rnd_wide(); step();
        peek_all("R6");

        reg_wr(4'h0, 32'hFFFF_FFFE); step();
        peek(4'h0, "R4");
        reg_wr(4'h0, 32'h1); step();
        peek(4'h0, "R4");
        rd_valid = 1'b0; rd_ue = 1'b1; rd_data = rnd_wide(); step();
        peek_all("R6");
        rd_valid = 1'b1; rd_ue = 1'b0; step();
        peek_all("R6");

        ue_read(rnd_wide(), 16'h00FF); step();
        d2 = rnd_wide();
        ue_read(d2, 16'hBEEF); reg_wr(4'h0, 32'h1); step();
        peek_all("R5");
        chk("R5", {96'b0, exp_read(4'h7)}, {96'b0, d2[127:96]});

        for (int a = 4; a <= 8; a++) begin
            reg_wr(a[3:0], 32'hDEAD_BEEF); step();
            peek_all("R12");
        end
        peek(4'h8, "R7");

        reg_wr(4'hC, 32'h0000_0020); step();
        peek(4'hC, "R10");
        wr_data_in = rnd_wide(); wr_ecc_in = 16'h3C3C; step();
        peek(4'hC, "R10");
        wr_valid = 1'b1; wr_data_in = rnd_wide(); step();
        peek(4'hC, "R10");
        wr_valid = 1'b1; wr_data_in = rnd_wide(); step();

        reg_wr(4'hC, 32'h8000_0001); step();
        wr_valid = 1'b1; wr_data_in = rnd_wide(); reg_wr(4'hC, 32'h0030_0000); step();
        peek(4'hC, "R11");
        wr_valid = 1'b1; wr_data_in = rnd_wide(); step();
        peek(4'hC, "R10");

        for (int i = 0; i < 3000; i++) begin
            logic [3:0] addrs [8];
            int r;
            addrs = '{4'h0, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'hC, 4'h9};
            rd_valid = ($urandom_range(1) == 1);
            rd_ue = ($urandom_range(7) == 0);
            rd_data = rnd_wide();
            rd_ecc = EW'($urandom());
            wr_valid = ($urandom_range(3) == 0);
            wr_data_in = rnd_wide();
            wr_ecc_in = EW'($urandom());
            reg_addr = addrs[$urandom_range(7)];
            r = $urandom_range(9);
            if (r == 0) begin
                reg_we = 1'b1; reg_addr = 4'h0; reg_wdata = {$urandom(), 1'b1} >> 1 | 32'h1;
            end else if (r == 1) begin
                reg_we = 1'b1; reg_addr = 4'hC;
                reg_wdata = (32'h1 << $urandom_range(31)) | (($urandom_range(1) == 1) ? (32'h1 << $urandom_range(31)) : 32'h0);
            end else if (r == 2) begin
                reg_we = 1'b1; reg_wdata = $urandom();
            end
            step();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule